// File: doc/BRIEF.md
# RV32IM Integer Arithmetic Unit

This block is the single-cycle integer arithmetic unit of a 32-bit RISC-V core. It takes two operands and a five-bit operation code. It returns one result in the same cycle. It has no clock, no reset and no internal state, so the result follows the inputs through combinational logic only.

The unit covers the base integer operations and all eight multiply and divide operations of the M extension. Division by zero and signed overflow never raise an exception. Each of these cases returns a fixed result value instead. Branch comparison, condition flags and iterative division belong to other units. The core's decoder drives the operation code, and the result goes to the write-back path.

The width is the parameter `XLEN`, which must be a power of two and at least 4. The default is 32.

Top module: `rv_int_alu`

## Requirements
- R1: Code 0 returns the sum of the operands and code 1 returns `opa - opb`. Both wrap modulo 2^XLEN.
- R2: Code 2 returns the bitwise AND of the operands, code 3 the bitwise OR and code 4 the bitwise XOR.
- R3: Code 5 returns 1 when `opa < opb` as two's-complement values and 0 otherwise. Code 6 makes the same comparison on unsigned values. All upper result bits are zero.
- R4: The shift amount is the low log2(XLEN) bits of `opb`, and the upper bits of `opb` are ignored. Code 7 shifts `opa` left and code 8 shifts it right. Both fill the vacated positions with zeros.
- R5: Code 9 shifts `opa` right and copies its sign bit into every vacated position.
- R6: Code 10 returns the low XLEN bits of the product of the operands.
- R7: Codes 11, 12 and 13 return the upper XLEN bits of the 2*XLEN-bit product. The operands are taken as signed×signed (11), signed `opa` × unsigned `opb` (12) and unsigned×unsigned (13).
- R8: Codes 14 (signed) and 15 (unsigned) return the quotient rounded toward zero. Codes 16 (signed) and 17 (unsigned) return the matching remainder. A signed remainder takes the sign of the dividend.
- R9: When `opb` is zero, codes 14 and 15 return all ones, and codes 16 and 17 return `opa` unchanged.
- R10: For signed division of the most negative value by -1, code 14 returns the most negative value and code 16 returns 0.
- R11: Codes 18 to 31 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 5 | Operation code |
| opa | input | XLEN | First operand (dividend, value to shift) |
| opb | input | XLEN | Second operand (divisor, shift amount) |
| result | output | XLEN | Result of the selected operation |

## Verification
A 4-bit copy of the unit is swept over every operand pair and every one of the 32 codes. This sweep covers each sign pattern, every shift amount, zero divisors and the most-negative-by-minus-one case, so it separates signed from unsigned handling in every operation.

The 32-bit unit is driven with a grid of boundary values: zero, one, all ones, the most negative and most positive values, and mixed bit patterns. This grid shows whether sign bits, high product halves and shift masks scale to full width. A stream of pseudo-random operand pairs then separates wrong bit slices in the high multiplies and sign fix-ups in the divider, which boundary values alone can hide.

// File: rtl/rv_alu_pkg.sv
`timescale 1ns/1ps
package rv_alu_pkg;
    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD    = 5'd0,
        OP_SUB    = 5'd1,
        OP_AND    = 5'd2,
        OP_OR     = 5'd3,
        OP_XOR    = 5'd4,
        OP_SLT    = 5'd5,
        OP_SLTU   = 5'd6,
        OP_SLL    = 5'd7,
        OP_SRL    = 5'd8,
        OP_SRA    = 5'd9,
        OP_MUL    = 5'd10,
        OP_MULH   = 5'd11,
        OP_MULHSU = 5'd12,
        OP_MULHU  = 5'd13,
        OP_DIV    = 5'd14,
        OP_DIVU   = 5'd15,
        OP_REM    = 5'd16,
        OP_REMU   = 5'd17
    } alu_op_e;

    typedef enum logic [1:0] {
        GRP_BASE = 2'd0,
        GRP_MUL  = 2'd1,
        GRP_DIV  = 2'd2,
        GRP_NONE = 2'd3
    } alu_grp_e;
endpackage

// File: rtl/alu_base.sv
`timescale 1ns/1ps
module alu_base
    import rv_alu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_e           op,
    input  logic [XLEN-1:0]   a,
    input  logic [XLEN-1:0]   b,
    output logic [XLEN-1:0]   res
);
    localparam int SHW = $clog2(XLEN);

    logic [SHW-1:0]  shamt;
    logic [XLEN-1:0] res_d;

    assign shamt = b[SHW-1:0];

    always_comb begin
        case (op)
            OP_ADD:  res_d = a + b;
            OP_SUB:  res_d = a - b;
            OP_AND:  res_d = a & b;
            OP_OR:   res_d = a | b;
            OP_XOR:  res_d = a ^ b;
            OP_SLT:  res_d = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            OP_SLTU: res_d = {{(XLEN-1){1'b0}}, (a < b)};
            OP_SLL:  res_d = a << shamt;
            OP_SRL:  res_d = a >> shamt;
            OP_SRA:  res_d = $unsigned($signed(a) >>> shamt);
            default: res_d = '0;
        endcase
    end

    assign res = res_d;

    always_comb begin
        if (!$isunknown({op, a, b})) begin
            // R1: the difference plus the subtrahend restores the minuend
            if (op == OP_SUB)
                a_r1_sub_inverse: assert ((res_d + b) == a)
                    else $error("sub inverse broken");
            // R3: comparisons yield only 0 or 1
            if (op == OP_SLT || op == OP_SLTU)
                a_r3_bool_result: assert (res_d[XLEN-1:1] == '0)
                    else $error("compare result not boolean");
            // R4: a logical right shift by a nonzero amount clears the top bit
            if (op == OP_SRL && shamt != '0)
                a_r4_srl_zero_fill: assert (res_d[XLEN-1] == 1'b0)
                    else $error("srl top bit not zero");
            // R5: an arithmetic right shift keeps the sign bit
            if (op == OP_SRA)
                a_r5_sra_sign_kept: assert (res_d[XLEN-1] == a[XLEN-1])
                    else $error("sra lost sign");
        end
    end
endmodule

// File: rtl/alu_mul.sv
`timescale 1ns/1ps
module alu_mul
    import rv_alu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_e           op,
    input  logic [XLEN-1:0]   a,
    input  logic [XLEN-1:0]   b,
    output logic [XLEN-1:0]   res
);
    localparam int PW = 2 * XLEN;

    logic            a_signed, b_signed;
    logic [PW-1:0]   a_ext, b_ext, prod;
    logic [XLEN-1:0] res_d;

    always_comb begin
        a_signed = (op == OP_MULH) || (op == OP_MULHSU);
        b_signed = (op == OP_MULH);
        // Extending to 2*XLEN and keeping the low 2*XLEN product bits gives the
        // exact product for each signedness.
        a_ext = {{XLEN{a_signed & a[XLEN-1]}}, a};
        b_ext = {{XLEN{b_signed & b[XLEN-1]}}, b};
        prod  = a_ext * b_ext;
        case (op)
            OP_MUL:    res_d = prod[XLEN-1:0];
            OP_MULH,
            OP_MULHSU,
            OP_MULHU:  res_d = prod[PW-1:XLEN];
            default:   res_d = '0;
        endcase
    end

    assign res = res_d;

    always_comb begin
        if (!$isunknown({op, a, b})) begin
            // R6: low half equals a plain truncated product
            if (op == OP_MUL)
                a_r6_low_product: assert (res_d == XLEN'(a * b))
                    else $error("low product mismatch");
            // R7: a zero operand gives a zero high half
            if ((op == OP_MULH || op == OP_MULHSU || op == OP_MULHU) && (a == '0 || b == '0))
                a_r7_high_zero: assert (res_d == '0)
                    else $error("high half of zero product not zero");
        end
    end
endmodule

// File: rtl/alu_div.sv
`timescale 1ns/1ps
module alu_div
    import rv_alu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_e           op,
    input  logic [XLEN-1:0]   a,
    input  logic [XLEN-1:0]   b,
    output logic [XLEN-1:0]   res
);
    localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};

    logic            is_signed, want_rem, a_neg, b_neg, b_zero;
    logic [XLEN-1:0] a_mag, b_mag, b_safe, uq, ur, quo_d, rem_d, res_d;

    always_comb begin
        is_signed = (op == OP_DIV) || (op == OP_REM);
        want_rem  = (op == OP_REM) || (op == OP_REMU);
        a_neg     = is_signed & a[XLEN-1];
        b_neg     = is_signed & b[XLEN-1];
        b_zero    = (b == '0);
        a_mag     = a_neg ? (~a + 1'b1) : a;
        b_mag     = b_neg ? (~b + 1'b1) : b;
        b_safe    = b_zero ? {{(XLEN-1){1'b0}}, 1'b1} : b_mag;
        uq        = a_mag / b_safe;
        ur        = a_mag % b_safe;
        // Magnitude arithmetic makes MOST_NEG / -1 wrap back to MOST_NEG with a
        // zero remainder, the defined overflow result.
        quo_d     = (a_neg ^ b_neg) ? (~uq + 1'b1) : uq;
        rem_d     = a_neg ? (~ur + 1'b1) : ur;
        if (b_zero) begin
            quo_d = '1;
            rem_d = a;
        end
        case (op)
            OP_DIV, OP_DIVU, OP_REM, OP_REMU: res_d = want_rem ? rem_d : quo_d;
            default:                          res_d = '0;
        endcase
    end

    assign res = res_d;

    always_comb begin
        if (!$isunknown({op, a, b})) begin
            // R8: quotient times divisor plus remainder rebuilds the dividend
            if (!b_zero && (op == OP_DIV || op == OP_DIVU || op == OP_REM || op == OP_REMU))
                a_r8_div_identity: assert (XLEN'(quo_d * b + rem_d) == a)
                    else $error("division identity broken");
            // R8: unsigned remainder stays below the divisor
            if (!b_zero && op == OP_REMU)
                a_r8_rem_bound: assert (rem_d < b)
                    else $error("unsigned remainder too large");
            // R10: overflow case yields most negative quotient, zero remainder
            if (is_signed && a == MOST_NEG && b == '1)
                a_r10_overflow: assert (quo_d == MOST_NEG && rem_d == '0)
                    else $error("signed overflow result wrong");
        end
    end
endmodule

// File: rtl/rv_int_alu.sv
`timescale 1ns/1ps
module rv_int_alu
    import rv_alu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [4:0]        op_sel,
    input  logic [XLEN-1:0]   opa,
    input  logic [XLEN-1:0]   opb,
    output logic [XLEN-1:0]   result
);
    alu_op_e         op;
    alu_grp_e        grp_d;
    logic [XLEN-1:0] base_res, mul_res, div_res, res_d;

    assign op = alu_op_e'(op_sel);

    alu_base #(.XLEN(XLEN)) u_base (.op(op), .a(opa), .b(opb), .res(base_res));
    alu_mul  #(.XLEN(XLEN)) u_mul  (.op(op), .a(opa), .b(opb), .res(mul_res));
    alu_div  #(.XLEN(XLEN)) u_div  (.op(op), .a(opa), .b(opb), .res(div_res));

    always_comb begin
        if (op_sel <= 5'd9)       grp_d = GRP_BASE;
        else if (op_sel <= 5'd13) grp_d = GRP_MUL;
        else if (op_sel <= 5'd17) grp_d = GRP_DIV;
        else                      grp_d = GRP_NONE;
        case (grp_d)
            GRP_BASE: res_d = base_res;
            GRP_MUL:  res_d = mul_res;
            GRP_DIV:  res_d = div_res;
            default:  res_d = '0;
        endcase
    end

    assign result = res_d;

    always_comb begin
        if (!$isunknown({op_sel, opa, opb})) begin
            // R11: undefined codes leave every unit silent
            if (op_sel > 5'd17)
                a_r11_unused_code: assert (base_res == '0 && mul_res == '0 && div_res == '0)
                    else $error("unit active on unused code");
        end
    end
endmodule

// File: tb/sim_rv_int_alu.sv
`timescale 1ns/1ps
module sim_rv_int_alu;
    localparam int WD_LIMIT = 150000;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [4:0]  op32, op4;
    logic [31:0] a32, b32, r32;
    logic [3:0]  a4, b4, r4;

    rv_int_alu #(.XLEN(32)) u0 (.op_sel(op32), .opa(a32), .opb(b32), .result(r32));
    rv_int_alu #(.XLEN(4))  u1 (.op_sel(op4),  .opa(a4),  .opb(b4),  .result(r4));

    function automatic longint sx(longint unsigned v, int w);
        longint t;
        t = longint'(v & ((64'd1 << w) - 1));
        if (t[w-1]) t = t - (longint'(1) << w);
        return t;
    endfunction

    function automatic longint unsigned ref_alu(int op, longint unsigned a, longint unsigned b, int w);
        longint unsigned m, r;
        longint sa, sb, mn, p;
        int sh;
        m  = (64'd1 << w) - 1;
        a  = a & m;
        b  = b & m;
        sa = sx(a, w);
        sb = sx(b, w);
        mn = -(longint'(1) << (w - 1));
        sh = int'(b & longint'(w - 1));
        case (op)
            0:  r = a + b;
            1:  r = a - b;
            2:  r = a & b;
            3:  r = a | b;
            4:  r = a ^ b;
            5:  r = (sa < sb) ? 1 : 0;
            6:  r = (a < b) ? 1 : 0;
            7:  r = a << sh;
            8:  r = a >> sh;
            9:  r = $unsigned(sa >>> sh);
            10: r = a * b;
            11: begin p = sa * sb; r = $unsigned(p >>> w); end
            12: begin p = sa * longint'(b); r = $unsigned(p >>> w); end
            13: r = (a * b) >> w;
            14: r = (b == 0) ? m : ((sa == mn && sb == -1) ? a : $unsigned(sa / sb));
            15: r = (b == 0) ? m : a / b;
            16: r = (b == 0) ? a : ((sa == mn && sb == -1) ? 0 : $unsigned(sa % sb));
            17: r = (b == 0) ? a : a % b;
            default: r = 0;
        endcase
        return r & m;
    endfunction

    function automatic string tag_for(int op, longint unsigned a, longint unsigned b, int w);
        longint unsigned m;
        m = (64'd1 << w) - 1;
        if (op >= 14 && op <= 17 && (b & m) == 0) return "R9";
        if ((op == 14 || op == 16) && (a & m) == (64'd1 << (w - 1)) && (b & m) == m) return "R10";
        case (op)
            0, 1:        return "R1";
            2, 3, 4:     return "R2";
            5, 6:        return "R3";
            7, 8:        return "R4";
            9:           return "R5";
            10:          return "R6";
            11, 12, 13:  return "R7";
            14, 15, 16, 17: return "R8";
            default:     return "R11";
        endcase
    endfunction

    task automatic chk(string tag, string what, longint unsigned got, longint unsigned exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    task automatic run32(int op, logic [31:0] a, logic [31:0] b);
        op32 = 5'(op); a32 = a; b32 = b;
        #1;
        chk(tag_for(op, a, b, 32), $sformatf("w32 op=%0d a=%0h b=%0h", op, a, b),
            longint'(r32), ref_alu(op, a, b, 32));
    endtask

    logic [31:0] corners [12];

    initial begin
        logic [31:0] lf;
        corners = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'h2,
                    32'hFFFF_FFFE, 32'h0000_001F, 32'h0000_0020, 32'hDEAD_BEEF,
                    32'h1234_5678, 32'h8000_0001};
        op32 = '0; a32 = '0; b32 = '0; op4 = '0; a4 = '0; b4 = '0;
        #3;
        // idle inputs: add of zeros gives zero (R1)
        chk("R1", "idle zero result", longint'(r32), 0);
        chk("R1", "idle zero result w4", longint'(r4), 0);

        // exhaustive 4-bit sweep across all codes
        for (int op = 0; op < 32; op++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++) begin
                    op4 = 5'(op); a4 = 4'(a); b4 = 4'(b);
                    #1;
                    chk(tag_for(op, a, b, 4), $sformatf("w4 op=%0d a=%0h b=%0h", op, a, b),
                        longint'(r4), ref_alu(op, a, b, 4));
                end

        // 32-bit boundary grid across all codes
        for (int op = 0; op < 32; op++)
            foreach (corners[i])
                foreach (corners[j])
                    run32(op, corners[i], corners[j]);

        // named corner checks
        run32(9, 32'h8000_0000, 32'h0000_003F);   // R5: sra by 31 through masked amount
        run32(7, 32'h0000_0001, 32'hFFFF_FFE4);   // R4: upper opb bits ignored
        run32(14, 32'h8000_0000, 32'hFFFF_FFFF);  // R10
        run32(16, 32'h8000_0000, 32'hFFFF_FFFF);  // R10
        run32(15, 32'hCAFE_0000, 32'h0);          // R9
        run32(17, 32'hCAFE_0000, 32'h0);          // R9
        run32(12, 32'hFFFF_FFFF, 32'hFFFF_FFFF);  // R7: mixed-sign high half
        run32(31, 32'hFFFF_FFFF, 32'h1);          // R11

        // pseudo-random 32-bit pairs on the defined codes
        lf = 32'h1ACE_B00C;
        for (int n = 0; n < 1500; n++) begin
            logic [31:0] x, y;
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            x = lf;
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            y = (n % 7 == 0) ? {28'h0, lf[3:0]} : lf;
            for (int op = 0; op < 18; op++) run32(op, x, y);
        end

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WD_LIMIT && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WD_LIMIT);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule